// File: doc/BRIEF.md
# Byte-Code Instruction Fetch Aligner

This block turns a stream of 16-bit code words into a stream of decoded byte-coded instructions. It keeps a byte program counter, reads whole words from code memory through a single-outstanding request/valid port, and picks opcode and operand bytes out of a two-word window. Within a code word, the even byte address sits in the low half and the odd byte address sits in the high half. An attribute table with one entry per opcode value gives each instruction's length and behaviour. Software loads this table through a configuration write port.

Two alignment rules shape the byte stream. A three-byte instruction whose opcode sits at an even address skips the odd byte and takes both operand bytes from the following word. A one-byte instruction flagged as aligned skips the odd byte of its word in the same way. For every instruction the block presents the opcode, the operand bytes, the length, the byte address of the last byte and a jump target measured from that last byte. A downstream executor takes instructions over a valid/ready handshake and may redirect the stream by taking a jump or by loading the PC.

A small combinational converter also maps between the byte PC and the signed word encoding kept in saved frames.

Top module: `bc_fetch_align`

## Requirements
- R1: After reset the block is idle: fetch_req, ins_valid and trap_valid stay low until the first pc_load.
- R2: Writing cfg_attr at index cfg_op with cfg_we replaces that opcode's entry. Entry bits are len[1:0], align[2], sext[3], jump[4], disp[10:5]. len 0 means undefined, and reset makes every entry undefined.
- R3: Byte b of a code word is taken from bits [7:0] when b is even and from bits [15:8] when b is odd. A stream of one-byte instructions advances the PC by one per instruction.
- R4: A two-byte instruction's alpha is the byte after the opcode, and this may be in the next word. The operand is alpha zero-extended, or sign-extended when sext is set. ins_last_pc is pc+1.
- R5: A three-byte instruction at an even address skips the odd byte. Alpha is bits [15:8] and beta is bits [7:0] of the next word. The operand is {alpha,beta}, ins_last_pc is pc+3, and the next opcode is at pc+4.
- R6: A three-byte instruction at an odd address takes alpha from bits [7:0] and beta from bits [15:8] of the next word. ins_last_pc is pc+2 and the next opcode is at pc+3.
- R7: An aligned one-byte instruction at an even address makes the next opcode come from pc+2. At an odd address it advances by one.
- R8: ins_len reports 1, 2 or 3. One-byte instructions report operand 0 and ins_last_pc equal to their own address.
- R9: ins_target equals ins_last_pc plus the displacement. For a one-byte jump the displacement is disp sign-extended (range -32..31); otherwise it is the operand.
- R10: An accepted instruction with jmp_take and ins_is_jump set, or a pc_load, redirects the PC. ins_valid is low in the next cycle and stays low until a word from the new address returns. Responses to stale requests are discarded.
- R11: While ins_valid is high and ins_ready is low (no pc_load), the instruction outputs hold steady.
- R12: An undefined opcode at the PC raises trap_valid for exactly one cycle with trap_pc set to its address. The opcode is never issued, and the block stalls until pc_load.
- R13: enc_word is pc/2 for an even pc and -(pc>>1) for an odd pc. dec_pc is 2v for v >= 0 and 2(-v)+1 for v < 0.
- R14: At most one word read is outstanding, so fetch_req is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Attribute table write strobe |
| cfg_op | input | 8 | Opcode whose entry is written |
| cfg_attr | input | 11 | New attribute entry |
| pc_load | input | 1 | Load the byte PC and flush |
| pc_load_addr | input | 16 | Byte address loaded |
| fetch_req | output | 1 | Word read request (one-cycle pulse) |
| fetch_waddr | output | 15 | Word address requested |
| fetch_rvalid | input | 1 | Read data returned |
| fetch_rdata | input | 16 | Returned code word |
| ins_valid | output | 1 | Instruction presented |
| ins_ready | input | 1 | Executor accepts instruction |
| ins_opcode | output | 8 | Opcode byte |
| ins_alpha | output | 8 | First operand byte |
| ins_beta | output | 8 | Second operand byte |
| ins_len | output | 2 | Instruction length in bytes |
| ins_operand | output | 16 | Extended operand |
| ins_last_pc | output | 16 | Byte address of last instruction byte |
| ins_is_jump | output | 1 | Entry marks a jump |
| ins_target | output | 16 | Jump target byte address |
| jmp_take | input | 1 | Take the jump on acceptance |
| trap_valid | output | 1 | Undefined-opcode trap pulse |
| trap_pc | output | 16 | Address of the undefined opcode |
| enc_pc | input | 16 | Byte PC to encode |
| enc_word | output | 16 | Signed saved-frame word |
| dec_word | input | 16 | Saved-frame word to decode |
| dec_pc | output | 16 | Decoded byte PC |

## Verification
The bench walks a program that puts two-byte operands across a word boundary and three-byte instructions at both parities. A design with the wrong byte order or parity would return swapped alpha/beta or a last address off by one. Aligned one-byte opcodes sit at both an even and an odd address, so a skip applied to the wrong parity shows up as a missing or misplaced opcode. A taken jump is followed by a not-taken one with a negative operand, and a one-byte jump uses displacement -32. These expose targets measured from the opcode, wrong sign extension, and prefetched words that survive the flush. The bench also ends a run on an undefined opcode and pulls pc_load while an instruction is stalled, to catch a repeated trap pulse or an instruction that leaks out of a flush.

// File: rtl/bc_fetch_pkg.sv
package bc_fetch_pkg;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int PC_W    = 16;
  localparam int WA_W    = PC_W - 1;
  localparam int OP_W    = BYTE_W;
  localparam int NUM_OPS = 2 ** OP_W;
  localparam int DISP_W  = 6;

  typedef struct packed {
    logic [DISP_W-1:0] disp;
    logic              jump;
    logic              sext;
    logic              align;
    logic [1:0]        len;
  } attr_t;

  localparam int ATTR_W = $bits(attr_t);
endpackage

// File: rtl/bc_attr_table.sv
module bc_attr_table
  import bc_fetch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [OP_W-1:0]   waddr,
  input  logic [ATTR_W-1:0] wdata,
  input  logic [OP_W-1:0]   raddr,
  output attr_t             rdata
);
  attr_t tbl_q [NUM_OPS];

  // each entry has its own enable; reset leaves every entry undefined
  for (genvar g = 0; g < NUM_OPS; g++) begin : g_ent
    logic ent_en;
    assign ent_en = we && (waddr == OP_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tbl_q[g] <= '0;
      else if (ent_en) tbl_q[g] <= attr_t'(wdata);
    end
  end

  assign rdata = tbl_q[raddr];
endmodule

// File: rtl/bc_ins_extract.sv
module bc_ins_extract
  import bc_fetch_pkg::*;
(
  input  logic [PC_W-1:0]   pc,
  input  logic [WORD_W-1:0] w0,
  input  logic [WORD_W-1:0] w1,
  input  logic              v0,
  input  logic              v1,
  input  attr_t             attr,
  output logic [OP_W-1:0]   opcode,
  output logic [BYTE_W-1:0] alpha,
  output logic [BYTE_W-1:0] beta,
  output logic [WORD_W-1:0] operand,
  output logic [1:0]        len,
  output logic [PC_W-1:0]   last_pc,
  output logic [PC_W-1:0]   next_pc,
  output logic [PC_W-1:0]   target,
  output logic              is_jump,
  output logic              undef,
  output logic              complete
);
  logic              odd;
  logic              need_w1;
  logic [WORD_W-1:0] jdisp;

  assign odd     = pc[0];
  assign opcode  = odd ? w0[WORD_W-1:BYTE_W] : w0[BYTE_W-1:0];
  assign len     = attr.len;
  assign undef   = (attr.len == 2'd0);
  assign is_jump = attr.jump;

  always_comb begin
    alpha   = '0;
    beta    = '0;
    operand = '0;
    need_w1 = 1'b0;
    last_pc = pc;
    next_pc = pc + PC_W'(1);
    case (attr.len)
      2'd1: begin
        if (attr.align && !odd) next_pc = pc + PC_W'(2);
      end
      2'd2: begin
        need_w1 = odd;
        alpha   = odd ? w1[BYTE_W-1:0] : w0[WORD_W-1:BYTE_W];
        last_pc = pc + PC_W'(1);
        next_pc = pc + PC_W'(2);
        operand = attr.sext ? {{(WORD_W-BYTE_W){alpha[BYTE_W-1]}}, alpha}
                            : {{(WORD_W-BYTE_W){1'b0}}, alpha};
      end
      2'd3: begin
        need_w1 = 1'b1;
        if (odd) begin
          alpha   = w1[BYTE_W-1:0];
          beta    = w1[WORD_W-1:BYTE_W];
          last_pc = pc + PC_W'(2);
          next_pc = pc + PC_W'(3);
        end else begin
          alpha   = w1[WORD_W-1:BYTE_W];
          beta    = w1[BYTE_W-1:0];
          last_pc = pc + PC_W'(3);
          next_pc = pc + PC_W'(4);
        end
        operand = {alpha, beta};
      end
      default: ;
    endcase
  end

  assign jdisp = (attr.len == 2'd1)
               ? {{(WORD_W-DISP_W){attr.disp[DISP_W-1]}}, attr.disp}
               : operand;
  assign target   = last_pc + PC_W'(jdisp);
  assign complete = v0 && (!need_w1 || v1);
endmodule

// File: rtl/bc_pc_codec.sv
module bc_pc_codec
  import bc_fetch_pkg::*;
(
  input  logic [PC_W-1:0]   enc_pc,
  output logic [WORD_W-1:0] enc_word,
  input  logic [WORD_W-1:0] dec_word,
  output logic [PC_W-1:0]   dec_pc
);
  logic [WORD_W-1:0] half;
  logic [WORD_W-1:0] neg_dec;

  assign half     = WORD_W'({1'b0, enc_pc[PC_W-1:1]});
  assign enc_word = enc_pc[0] ? (WORD_W'(0) - half) : half;

  assign neg_dec  = WORD_W'(0) - dec_word;
  assign dec_pc   = dec_word[WORD_W-1] ? {neg_dec[PC_W-2:0], 1'b1}
                                       : {dec_word[PC_W-2:0], 1'b0};
endmodule

// File: rtl/bc_fetch_align.sv
module bc_fetch_align
  import bc_fetch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [OP_W-1:0]   cfg_op,
  input  logic [ATTR_W-1:0] cfg_attr,
  input  logic              pc_load,
  input  logic [PC_W-1:0]   pc_load_addr,
  output logic              fetch_req,
  output logic [WA_W-1:0]   fetch_waddr,
  input  logic              fetch_rvalid,
  input  logic [WORD_W-1:0] fetch_rdata,
  output logic              ins_valid,
  input  logic              ins_ready,
  output logic [OP_W-1:0]   ins_opcode,
  output logic [BYTE_W-1:0] ins_alpha,
  output logic [BYTE_W-1:0] ins_beta,
  output logic [1:0]        ins_len,
  output logic [WORD_W-1:0] ins_operand,
  output logic [PC_W-1:0]   ins_last_pc,
  output logic              ins_is_jump,
  output logic [PC_W-1:0]   ins_target,
  input  logic              jmp_take,
  output logic              trap_valid,
  output logic [PC_W-1:0]   trap_pc,
  input  logic [PC_W-1:0]   enc_pc,
  output logic [WORD_W-1:0] enc_word,
  input  logic [WORD_W-1:0] dec_word,
  output logic [PC_W-1:0]   dec_pc
);
  // window state: w0 holds the word containing pc, w1 the word after it
  logic [PC_W-1:0]   pc_q,   pc_n;
  logic [WORD_W-1:0] w0_q,   w0_n;
  logic [WORD_W-1:0] w1_q,   w1_n;
  logic              v0_q,   v0_n;
  logic              v1_q,   v1_n;
  logic              busy_q, busy_n;
  logic              drop_q, drop_n;
  logic              halt_q, halt_n;
  logic [WA_W-1:0]   rwa_q,  rwa_n;

  attr_t             attr;
  logic [PC_W-1:0]   next_pc;
  logic              undef;
  logic              complete;
  logic              accept;
  logic              redirect;
  logic [WA_W-1:0]   base_n;
  logic [WA_W-1:0]   step;

  bc_attr_table i_table (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .waddr (cfg_op),
    .wdata (cfg_attr),
    .raddr (ins_opcode),
    .rdata (attr)
  );

  bc_ins_extract i_extract (
    .pc       (pc_q),
    .w0       (w0_q),
    .w1       (w1_q),
    .v0       (v0_q),
    .v1       (v1_q),
    .attr     (attr),
    .opcode   (ins_opcode),
    .alpha    (ins_alpha),
    .beta     (ins_beta),
    .operand  (ins_operand),
    .len      (ins_len),
    .last_pc  (ins_last_pc),
    .next_pc  (next_pc),
    .target   (ins_target),
    .is_jump  (ins_is_jump),
    .undef    (undef),
    .complete (complete)
  );

  bc_pc_codec i_codec (
    .enc_pc   (enc_pc),
    .enc_word (enc_word),
    .dec_word (dec_word),
    .dec_pc   (dec_pc)
  );

  assign ins_valid   = complete && !undef && !halt_q;
  assign trap_valid  = v0_q && undef && !halt_q;
  assign trap_pc     = pc_q;
  assign accept      = ins_valid && ins_ready;
  assign redirect    = pc_load || (accept && jmp_take && ins_is_jump);

  assign fetch_req   = !busy_q && !halt_q && !redirect && (!v0_q || !v1_q);
  assign fetch_waddr = v0_q ? (pc_q[PC_W-1:1] + WA_W'(1)) : pc_q[PC_W-1:1];

  assign step        = next_pc[PC_W-1:1] - pc_q[PC_W-1:1];

  always_comb begin
    pc_n   = pc_q;
    w0_n   = w0_q;
    w1_n   = w1_q;
    v0_n   = v0_q;
    v1_n   = v1_q;
    busy_n = busy_q;
    drop_n = drop_q;
    halt_n = halt_q;
    rwa_n  = rwa_q;

    // advance or redirect the window
    if (redirect) begin
      pc_n   = pc_load ? pc_load_addr : ins_target;
      v0_n   = 1'b0;
      v1_n   = 1'b0;
      halt_n = 1'b0;
      if (busy_q && !fetch_rvalid) drop_n = 1'b1;
    end else if (accept) begin
      pc_n = next_pc;
      if (step == WA_W'(1)) begin
        w0_n = w1_q;
        v0_n = v1_q;
        v1_n = 1'b0;
      end else if (step != WA_W'(0)) begin
        v0_n = 1'b0;
        v1_n = 1'b0;
      end
    end else if (trap_valid) begin
      halt_n = 1'b1;
    end

    // land a returned word in whichever slot it now belongs to
    base_n = pc_n[PC_W-1:1];
    if (fetch_rvalid) begin
      busy_n = 1'b0;
      drop_n = 1'b0;
      if (!drop_q && !redirect) begin
        if (rwa_q == base_n) begin
          w0_n = fetch_rdata;
          v0_n = 1'b1;
        end else if (rwa_q == base_n + WA_W'(1) && v0_n) begin
          w1_n = fetch_rdata;
          v1_n = 1'b1;
        end
      end
    end

    if (fetch_req) begin
      busy_n = 1'b1;
      rwa_n  = fetch_waddr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      w0_q   <= '0;
      w1_q   <= '0;
      v0_q   <= 1'b0;
      v1_q   <= 1'b0;
      busy_q <= 1'b0;
      drop_q <= 1'b0;
      halt_q <= 1'b1;
      rwa_q  <= '0;
    end else begin
      pc_q   <= pc_n;
      w0_q   <= w0_n;
      w1_q   <= w1_n;
      v0_q   <= v0_n;
      v1_q   <= v1_n;
      busy_q <= busy_n;
      drop_q <= drop_n;
      halt_q <= halt_n;
      rwa_q  <= rwa_n;
    end
  end
endmodule

// File: rtl/bc_fetch_align_chk.sv
module bc_fetch_align_chk
  import bc_fetch_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              pc_load,
  input logic              fetch_req,
  input logic              ins_valid,
  input logic              ins_ready,
  input logic [OP_W-1:0]   ins_opcode,
  input logic [1:0]        ins_len,
  input logic [WORD_W-1:0] ins_operand,
  input logic [PC_W-1:0]   ins_last_pc,
  input logic              ins_is_jump,
  input logic              jmp_take,
  input logic              trap_valid
);
  a_r14_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> !fetch_req);

  a_r11_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !ins_ready && !pc_load) |=>
      (ins_valid && $stable(ins_opcode) && $stable(ins_last_pc) && $stable(ins_operand)));

  a_r10_load_flush: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !ins_valid);

  a_r10_jump_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready && jmp_take && ins_is_jump) |=> !ins_valid);

  a_r12_trap_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> !trap_valid);

  a_r12_trap_not_issued: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> !ins_valid);

  a_r8_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |-> (ins_len != 2'd0));
endmodule

bind bc_fetch_align bc_fetch_align_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pc_load     (pc_load),
  .fetch_req   (fetch_req),
  .ins_valid   (ins_valid),
  .ins_ready   (ins_ready),
  .ins_opcode  (ins_opcode),
  .ins_len     (ins_len),
  .ins_operand (ins_operand),
  .ins_last_pc (ins_last_pc),
  .ins_is_jump (ins_is_jump),
  .jmp_take    (jmp_take),
  .trap_valid  (trap_valid)
);

// File: tb/test_bc_fetch_align.sv
module test_bc_fetch_align;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_op = '0;
  logic [10:0] cfg_attr = '0;
  logic        pc_load = 1'b0;
  logic [15:0] pc_load_addr = '0;
  logic        fetch_req;
  logic [14:0] fetch_waddr;
  logic        fetch_rvalid = 1'b0;
  logic [15:0] fetch_rdata = '0;
  logic        ins_valid;
  logic        ins_ready = 1'b0;
  logic [7:0]  ins_opcode, ins_alpha, ins_beta;
  logic [1:0]  ins_len;
  logic [15:0] ins_operand, ins_last_pc, ins_target;
  logic        ins_is_jump;
  logic        jmp_take = 1'b0;
  logic        trap_valid;
  logic [15:0] trap_pc;
  logic [15:0] enc_pc = '0, enc_word, dec_word = '0, dec_pc;

  int checks = 0;
  int failures = 0;
  int req_viol = 0;
  logic prev_req = 1'b0;

  always #2 clk = ~clk;

  bc_fetch_align i_bc_fetch_align (.*);

  // code memory with two-cycle read latency
  logic [15:0] mem [0:63];
  logic        p_v = 1'b0;
  logic [5:0]  p_a = '0;
  always @(posedge clk) begin
    p_v          <= fetch_req;
    p_a          <= fetch_waddr[5:0];
    fetch_rvalid <= p_v;
    fetch_rdata  <= mem[p_a];
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (fetch_req && prev_req) req_viol++;
      prev_req <= fetch_req;
    end
  end

  typedef struct packed {
    logic        take;
    logic [7:0]  op;
    logic [1:0]  len;
    logic [15:0] opnd;
    logic [15:0] last;
    logic [15:0] tgt;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b0, 8'h10, 2'd1, 16'h0000, 16'd16, 16'd0},   // R3
    '{1'b0, 8'h20, 2'd2, 16'h0085, 16'd18, 16'd0},   // R4 zero-ext, spans words
    '{1'b0, 8'h21, 2'd2, 16'hFF85, 16'd20, 16'd0},   // R4 sign-ext
    '{1'b0, 8'h30, 2'd3, 16'h1234, 16'd23, 16'd0},   // R6 odd
    '{1'b0, 8'h30, 2'd3, 16'h5678, 16'd27, 16'd0},   // R5 even
    '{1'b0, 8'h11, 2'd1, 16'h0000, 16'd28, 16'd0},   // R7 even skip
    '{1'b0, 8'h10, 2'd1, 16'h0000, 16'd30, 16'd0},   // R7
    '{1'b0, 8'h11, 2'd1, 16'h0000, 16'd31, 16'd0},   // R7 odd no skip
    '{1'b1, 8'h40, 2'd1, 16'h0000, 16'd32, 16'd38},  // R9 taken
    '{1'b0, 8'h41, 2'd2, 16'hFFF0, 16'd39, 16'd23},  // R9 not taken
    '{1'b0, 8'h10, 2'd1, 16'h0000, 16'd40, 16'd0}    // R8
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] attr(input int len, input bit al, input bit sx,
                                       input bit jp, input int disp);
    logic [5:0] d;
    logic [1:0] l;
    d = 6'(disp);
    l = 2'(len);
    return {d, jp, sx, al, l};
  endfunction

  task automatic cfg(input logic [7:0] op, input logic [10:0] a);
    cfg_we = 1'b1; cfg_op = op; cfg_attr = a;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load(input logic [15:0] a);
    pc_load = 1'b1; pc_load_addr = a;
    @(negedge clk);
    pc_load = 1'b0;
  endtask

  task automatic wait_valid(input string req);
    for (int n = 0; n < 60 && !ins_valid; n++) @(negedge clk);
    chk({req, " ins_valid arrives"}, ins_valid, 1'b1);
  endtask

  task automatic consume(input vec_t v, input int hold, input string req);
    logic [15:0] s_last, s_opnd;
    logic [7:0]  s_op;
    wait_valid(req);
    s_last = ins_last_pc; s_opnd = ins_operand; s_op = ins_opcode;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk("R11 stall hold", {ins_valid, s_op, s_last}, {1'b1, ins_opcode, ins_last_pc});
      chk("R11 stall operand", s_opnd, ins_operand);
    end
    chk({req, " opcode"}, ins_opcode, v.op);
    chk({req, " len R8"}, ins_len, v.len);
    chk({req, " operand"}, ins_operand, v.opnd);
    chk({req, " last_pc R8"}, ins_last_pc, v.last);
    if (v.op[7:4] == 4'h4) chk({req, " target R9"}, ins_target, v.tgt);
    ins_ready = 1'b1;
    jmp_take  = v.take;
    @(negedge clk);
    if (v.take) chk("R10 invalid after taken jump", ins_valid, 1'b0);
    ins_ready = 1'b0;
    jmp_take  = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
    mem[8]  = 16'h2010; mem[9]  = 16'h2185; mem[10] = 16'h3085;
    mem[11] = 16'h3412; mem[12] = 16'hEE30; mem[13] = 16'h5678;
    mem[14] = 16'hEE11; mem[15] = 16'h1110; mem[16] = 16'hEE40;
    mem[17] = 16'hEEEE; mem[18] = 16'hEEEE; mem[19] = 16'hF041;
    mem[20] = 16'h0010; mem[24] = 16'hEE42;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      chk("R1 idle after reset", {fetch_req, ins_valid, trap_valid}, 3'b000);
    end

    cfg(8'h10, attr(1, 0, 0, 0, 0));
    cfg(8'h11, attr(1, 1, 0, 0, 0));
    cfg(8'h20, attr(2, 0, 0, 0, 0));
    cfg(8'h21, attr(2, 0, 1, 0, 0));
    cfg(8'h30, attr(3, 0, 0, 0, 0));
    cfg(8'h40, attr(1, 0, 0, 1, 6));
    cfg(8'h41, attr(2, 0, 1, 1, 0));
    cfg(8'h42, attr(1, 0, 0, 1, -32));
    chk("R1 still idle before load", {fetch_req, ins_valid}, 2'b00);

    load(16'd16);
    for (int i = 0; i < NV; i++) consume(VEC[i], i % 3, "R3-stream");

    // R12: undefined opcode 0x00 at byte 41
    for (int n = 0; n < 60 && !trap_valid; n++) @(negedge clk);
    chk("R12 trap raised", trap_valid, 1'b1);
    chk("R12 trap pc", trap_pc, 16'd41);
    chk("R12 trap blocks issue", ins_valid, 1'b0);
    @(negedge clk);
    chk("R12 trap one cycle", trap_valid, 1'b0);
    repeat (5) @(negedge clk);
    chk("R12 stalled after trap", {ins_valid, trap_valid}, 2'b00);

    // R9: one-byte jump with displacement -32
    load(16'd48);
    consume('{1'b1, 8'h42, 2'd1, 16'h0000, 16'd48, 16'd16}, 0, "R9 back jump");
    consume('{1'b0, 8'h10, 2'd1, 16'h0000, 16'd16, 16'd0}, 1, "R9 landed");

    // R10: pc_load while an instruction is stalled
    wait_valid("R10 pre-load");
    chk("R10 pre-load opcode", ins_opcode, 8'h20);
    load(16'd30);
    chk("R10 flush on load", ins_valid, 1'b0);
    consume('{1'b0, 8'h10, 2'd1, 16'h0000, 16'd30, 16'd0}, 0, "R10 reload");

    // R2: rewrite entry 0x10 as a two-byte zero-extended instruction
    cfg(8'h10, attr(2, 0, 0, 0, 0));
    load(16'd16);
    consume('{1'b0, 8'h10, 2'd2, 16'h0020, 16'd17, 16'd0}, 0, "R2 rewritten entry");

    // R13: saved-frame PC conversion
    enc_pc = 16'd40; dec_word = 16'd20;
    @(negedge clk);
    chk("R13 encode even", enc_word, 16'd20);
    chk("R13 decode nonneg", dec_pc, 16'd40);
    enc_pc = 16'd41; dec_word = 16'hFFEC;
    @(negedge clk);
    chk("R13 encode odd", enc_word, 16'hFFEC);
    chk("R13 decode negative", dec_pc, 16'd41);
    dec_word = 16'hFFFF;
    @(negedge clk);
    chk("R13 decode minus one", dec_pc, 16'd3);

    chk("R14 no back-to-back requests", req_viol, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule